// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one data byte into a single asynchronous serial character on one output line. A pulse on the start input captures the data byte, a mode byte and a bit-rate byte together. The block then drives a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. When the character is complete it drops its busy flag and raises a done pulse for one clock. Between characters the line rests high.

The length of each bit is set by a two-stage divider inside the block. A prescaler divides the clock by 1, 4, 16 or 64, chosen by the mode byte. A bit counter then counts 32 times the bit-rate value of those prescaled ticks. The settings that were captured stay in force for the whole character, so the source may change the inputs as soon as busy rises. A new character may be started in the same cycle that the done pulse is high.

Top module: `async_frame_tx`

## Requirements
- R1: Out of reset, and whenever busy is low, the line `txd` is high. In the same cycle after reset, `busy` and `done` are low.
- R2: A `start` pulse sampled at a clock edge while `busy` is low is accepted. From that edge `busy` is high and `txd` carries the low start bit.
- R3: Every bit of the frame lasts 32 × N × 4^S clock cycles. S is mode bits [1:0]. N is the `rate` value, and a `rate` of 0 is taken as 256.
- R4: After the start bit, the data bits are sent least significant bit first. Mode bit 6 at 0 sends all 8 data bits. At 1 it sends only bits [6:0].
- R5: Mode bit 5 at 1 inserts a parity bit right after the last data bit. Mode bit 4 sets the parity sense: 0 gives even parity and 1 gives odd parity. Parity is computed over the data bits that are sent.
- R6: The stop bits follow, driven high. Mode bit 3 at 0 gives one stop bit and at 1 gives two. The frame therefore has 1 + data bits + parity bit + stop bits bit times.
- R7: `busy` falls at the clock edge that ends the last stop bit. `done` is high for exactly the one cycle that follows that edge.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The frame in flight, and the time it ends, are unchanged.
- R9: `data`, `mode` and `rate` are sampled only when a start is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a character (one-cycle strobe) |
| data | input | MAX_DATA (8) | Character to send |
| mode | input | 8 | Frame format and prescale select |
| rate | input | RATE_W (8) | Bit-rate multiplier, 0 taken as 256 |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-cycle pulse after the frame ends |

## Verification
Two things can fall on the same cycle: the end of a frame, where done is high and busy has just fallen, and a new start strobe. A strobe in the done cycle must be accepted at once. A strobe one cycle earlier, in the final busy cycle, must be dropped. The bench drives a strobe in the last busy cycle of every frame and checks that busy still falls on time. It then launches the next frame in the done cycle itself and checks that the new start bit begins on the very next edge. In both cases the bench judges the result from bit samples taken in the middle of each bit and from the exact cycle of busy and done, all computed from the mode fields.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

   localparam int MODE_W     = 8;
   localparam int SEL_W      = 2;
   localparam int MB_SEL_LO  = 0;
   localparam int MB_STOP2   = 3;
   localparam int MB_ODD     = 4;
   localparam int MB_PAR     = 5;
   localparam int MB_SHORT   = 6;

   typedef struct packed {
      logic             short_char;
      logic             par_en;
      logic             par_odd;
      logic             two_stop;
      logic [SEL_W-1:0] sel;
   } tx_fmt_t;

   function automatic tx_fmt_t decode_mode(input logic [MODE_W-1:0] m);
      tx_fmt_t f;
      f.short_char = m[MB_SHORT];
      f.par_en     = m[MB_PAR];
      f.par_odd    = m[MB_ODD];
      f.two_stop   = m[MB_STOP2];
      f.sel        = m[MB_SEL_LO +: SEL_W];
      return f;
   endfunction

endpackage

// File: rtl/async_tx_frame_build.sv
module async_tx_frame_build
   import async_tx_pkg::*;
#(
   parameter int MAX_DATA = 8,
   parameter int FRAME_W  = MAX_DATA + 4,
   parameter int LEN_W    = $clog2(FRAME_W + 1)
) (
   input  logic [MAX_DATA-1:0] data,
   input  tx_fmt_t             fmt,
   output logic [FRAME_W-1:0]  frame,
   output logic [LEN_W-1:0]    len
);

   logic [MAX_DATA-1:0] sent_bits;
   logic                par_bit;
   int                  nd;

   always_comb begin
      nd        = fmt.short_char ? MAX_DATA - 1 : MAX_DATA;
      sent_bits = data;
      if (fmt.short_char) sent_bits[MAX_DATA-1] = 1'b0;
      par_bit   = (^sent_bits) ^ fmt.par_odd;

      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < MAX_DATA; i++) begin
         if (i < nd) frame[i+1] = data[i];
      end
      for (int i = 1; i < FRAME_W; i++) begin
         if (fmt.par_en && (i == nd + 1)) frame[i] = par_bit;
      end
      len = LEN_W'(2 + nd + int'(fmt.par_en) + int'(fmt.two_stop));
   end

endmodule

// File: rtl/async_tx_baud_timer.sv
module async_tx_baud_timer #(
   parameter int SEL_W      = 2,
   parameter int RADIX_LOG2 = 2,
   parameter int OVERSAMPLE = 32,
   parameter int RATE_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [SEL_W-1:0]  sel,
   input  logic [RATE_W-1:0] rate,
   output logic              bit_end
);

   localparam int PC_W    = ((1 << SEL_W) - 1) * RADIX_LOG2;
   localparam int OS_LOG2 = $clog2(OVERSAMPLE);
   localparam int BC_W    = RATE_W + 1 + OS_LOG2;

   logic [PC_W-1:0]   pcnt, presc_max;
   logic [BC_W-1:0]   bcnt, bit_max;
   logic [RATE_W:0]   rate_eff;
   logic              ptick;

   assign presc_max = PC_W'((1 << (int'(sel) * RADIX_LOG2)) - 1);
   assign rate_eff  = (rate == '0) ? {1'b1, RATE_W'(0)} : {1'b0, rate};

   if (OS_LOG2 > 0 && OVERSAMPLE == (1 << OS_LOG2)) begin : g_shift_scale
      assign bit_max = {rate_eff, OS_LOG2'(0)} - BC_W'(1);
   end else begin : g_mult_scale
      assign bit_max = BC_W'(rate_eff) * BC_W'(OVERSAMPLE) - BC_W'(1);
   end

   assign ptick   = (pcnt == presc_max);
   assign bit_end = run && ptick && (bcnt == bit_max);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         bcnt <= '0;
      end else if (!run) begin
         pcnt <= '0;
         bcnt <= '0;
      end else begin
         pcnt <= ptick ? '0 : pcnt + PC_W'(1);
         if (ptick) bcnt <= (bcnt == bit_max) ? '0 : bcnt + BC_W'(1);
      end
   end

endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter #(
   parameter int FRAME_W = 12,
   parameter int LEN_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [LEN_W-1:0]   len_in,
   input  logic               bit_end,
   output logic               txd,
   output logic               busy,
   output logic               done
);

   logic [FRAME_W-1:0] sreg;
   logic [LEN_W-1:0]   left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '1;
         left <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            sreg <= frame_in;
            left <= len_in;
            busy <= 1'b1;
         end else if (busy && bit_end) begin
            sreg <= {1'b1, sreg[FRAME_W-1:1]};
            left <= left - LEN_W'(1);
            if (left == LEN_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign txd = busy ? sreg[0] : 1'b1;

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
   import async_tx_pkg::*;
#(
   parameter int MAX_DATA   = 8,
   parameter int RATE_W     = 8,
   parameter int OVERSAMPLE = 32,
   parameter int RADIX_LOG2 = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [MAX_DATA-1:0] data,
   input  logic [MODE_W-1:0]   mode,
   input  logic [RATE_W-1:0]   rate,
   output logic                txd,
   output logic                busy,
   output logic                done
);

   localparam int FRAME_W = MAX_DATA + 4;
   localparam int LEN_W   = $clog2(FRAME_W + 1);

   if (MAX_DATA < 2) begin : g_bad_data
      $error("MAX_DATA must be at least 2");
   end
   if (RATE_W < 1) begin : g_bad_rate
      $error("RATE_W must be at least 1");
   end
   if (OVERSAMPLE < 1) begin : g_bad_os
      $error("OVERSAMPLE must be at least 1");
   end
   if (RADIX_LOG2 < 1) begin : g_bad_radix
      $error("RADIX_LOG2 must be at least 1");
   end

   tx_fmt_t            fmt_in;
   logic [FRAME_W-1:0] frame_new;
   logic [LEN_W-1:0]   len_new;
   logic               accept;
   logic               bit_end;
   logic [SEL_W-1:0]   sel_q;
   logic [RATE_W-1:0]  rate_q;

   assign fmt_in = decode_mode(mode);
   assign accept = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         rate_q <= '0;
      end else if (accept) begin
         sel_q  <= fmt_in.sel;
         rate_q <= rate;
      end
   end

   async_tx_frame_build #(
      .MAX_DATA (MAX_DATA),
      .FRAME_W  (FRAME_W),
      .LEN_W    (LEN_W)
   ) u_build (
      .data  (data),
      .fmt   (fmt_in),
      .frame (frame_new),
      .len   (len_new)
   );

   async_tx_baud_timer #(
      .SEL_W      (SEL_W),
      .RADIX_LOG2 (RADIX_LOG2),
      .OVERSAMPLE (OVERSAMPLE),
      .RATE_W     (RATE_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .sel     (sel_q),
      .rate    (rate_q),
      .bit_end (bit_end)
   );

   async_tx_shifter #(
      .FRAME_W (FRAME_W),
      .LEN_W   (LEN_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .frame_in (frame_new),
      .len_in   (len_new),
      .bit_end  (bit_end),
      .txd      (txd),
      .busy     (busy),
      .done     (done)
   );

endmodule

// File: rtl/async_tx_checker.sv
module async_tx_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic txd,
   input logic busy,
   input logic done,
   input logic bit_end
);

   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   a_r2_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy && !txd);

   a_r3_line_holds_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !$past(bit_end) |-> $stable(txd));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bit_end) && $past(busy));

   a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      start && busy && !bit_end |=> busy && $stable(txd));

endmodule

bind async_frame_tx async_tx_checker i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .txd     (txd),
   .busy    (busy),
   .done    (done),
   .bit_end (bit_end)
);

// File: tb/test_async_frame_tx.sv
module test_async_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] data = 8'h00;
   logic [7:0] mode = 8'h00;
   logic [7:0] rate = 8'h01;
   logic       txd, busy, done;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   async_frame_tx i_async_frame_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .data  (data),
      .mode  (mode),
      .rate  (rate),
      .txd   (txd),
      .busy  (busy),
      .done  (done)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   function automatic int data_bits(input int m);
      return ((m >> 6) & 1) ? 7 : 8;
   endfunction

   function automatic int frame_bits(input int m);
      return 2 + data_bits(m) + ((m >> 5) & 1) + ((m >> 3) & 1);
   endfunction

   function automatic int bit_period(input int m, input int r);
      int n = (r == 0) ? 256 : r;
      return 32 * n * (1 << (2 * (m & 3)));
   endfunction

   function automatic int exp_bit(input int d, input int m, input int i);
      int nd = data_bits(m);
      int p;
      if (i == 0) return 0;
      if (i <= nd) return (d >> (i - 1)) & 1;
      if (((m >> 5) & 1) && i == nd + 1) begin
         p = (m >> 4) & 1;
         for (int k = 0; k < nd; k++) p ^= (d >> k) & 1;
         return p;
      end
      return 1;
   endfunction

   // Called at a negedge; returns at the negedge of the done cycle.
   task automatic send(input int d, input int m, input int r);
      int pp = bit_period(m, r);
      int nb = frame_bits(m);
      int last = nb * pp;
      data  = 8'(d);
      mode  = 8'(m);
      rate  = 8'(r);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c <= last; c++) begin
         if (c == 0) begin
            chk("R2 busy after accept", int'(busy), 1);
            chk("R7 done low after accept", int'(done), 0);
            // R9: scramble captured inputs while the frame runs
            data = 8'($urandom);
            mode = 8'($urandom);
            rate = 8'($urandom);
         end
         if (c == pp) start = 1'b1;          // R8 mid-frame strobe
         if (c == pp + 1) start = 1'b0;
         if (c % pp == pp / 2) begin
            if (c / pp == 0)
               chk("R2 start bit low", int'(txd), 0);
            else if (c / pp <= data_bits(m))
               chk("R4 data bit LSB first", int'(txd), exp_bit(d, m, c / pp));
            else if (((m >> 5) & 1) && c / pp == data_bits(m) + 1)
               chk("R5 parity bit", int'(txd), exp_bit(d, m, c / pp));
            else
               chk("R6 stop bit high", int'(txd), 1);
         end
         if (c == last - 1) begin
            chk("R3 busy held to frame end", int'(busy), 1);
            chk("R7 no early done", int'(done), 0);
            start = 1'b1;                    // R8 strobe in last busy cycle
         end
         if (c == last) begin
            start = 1'b0;
            chk("R7 busy falls at end", int'(busy), 0);
            chk("R7 done pulse", int'(done), 1);
            chk("R1 line high at end", int'(txd), 1);
         end
         if (c < last) begin
            @(posedge clk);
            @(negedge clk);
         end
      end
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R1 idle line high", int'(txd), 1);
         chk("R1 idle not busy", int'(busy), 0);
         chk("R7 done single cycle", int'(done), 0);
      end
   endtask

   initial begin
      int sd;
      sd = $urandom(32'h1234_5eed);
      repeat (3) @(negedge clk);
      chk("R1 reset line", int'(txd), 1);
      chk("R1 reset busy", int'(busy), 0);
      chk("R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      idle(3);

      // Every format combination at the fastest rate, chained back to back
      for (int f = 0; f < 16; f++)
         send((f * 37 + 5) & 255, f << 3, 1);
      idle(2);
      send(8'h00, 8'h20, 1);                 // even parity of zero
      send(8'hFF, 8'h30, 1);                 // odd parity of all ones
      send(8'h80, 8'h60, 1);                 // 7-bit: bit 7 not counted
      idle(2);
      // R3 prescale and rate variants
      send(8'hA5, 8'h01, 1);
      send(8'h5A, 8'h02, 1);
      send(8'h3C, 8'h03, 1);
      send(8'hC3, 8'h00, 2);
      send(8'h96, 8'h40, 0);                 // rate 0 taken as 256
      idle(2);

      for (int t = 0; t < 30; t++) begin
         int m = int'($urandom) & 8'h78;
         int r = 1 + int'($urandom % 2);
         if ($urandom % 8 == 0) m |= 1;
         send(int'($urandom) & 255, m, r);
         if ($urandom % 3 == 0) idle(1 + int'($urandom % 3));
      end
      idle(2);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule